// File: doc/BRIEF.md
# Single-Instruction Transport Processor

This block is a small processor that has exactly one kind of instruction: a move. Each 16-bit instruction names a source port and a destination port. The sequencer reads the source port, drives that word onto one shared transport bus, and writes it into the destination port. Arithmetic and logic happen only as a side effect of such writes. Each functional unit has an operand port and one or more trigger ports. A write to a trigger port computes a result from the held operand and the word on the bus. The result is then read back later through the unit's result port.

An adder unit and a logic unit sit on the bus next to an input unit and an output unit. The input unit offers a streamed word and reports each time it is read. The output unit produces a one-cycle strobe with each word written to it. Three more ports have special meanings: a literal port that returns the next program word, a jump port that loads the program counter, and a stop port. The program is a fixed image given as a parameter. Adding a unit only claims a free block of port addresses; the instruction format and the sequencer stay unchanged. There is no pipeline, so each move finishes before the next fetch begins.

Top module: `ttmove_core`

## Requirements
- R1: An instruction word carries its source port address in bits 15:8 and its destination port address in bits 7:0, and every instruction is executed as a move of one 16-bit word from that source to that destination.
- R2: A move occupies two clock cycles (fetch, then transport), or three when its source is the literal port, and at most one transport happens in any cycle.
- R3: The adder holds an operand written to port 0x20; a write to port 0x21 produces operand plus bus word modulo 2^16, a write to port 0x22 produces operand minus bus word modulo 2^16, and the result is read from source port 0x20.
- R4: The logic unit holds an operand written to port 0x30; writes to ports 0x31, 0x32 and 0x33 produce AND, OR and XOR with the bus word, and the result is read from source port 0x30; a trigger reuses whatever operand is currently held.
- R5: A unit's result can be read by the very next move, and it keeps its value until that unit is triggered again, so results can be moved from one unit straight into another.
- R6: Reading source port 0x10 returns `in_data` and raises `in_take` for exactly the transport cycle of that move.
- R7: Writing destination port 0x11 raises `out_valid` for one cycle, with the moved word on `out_data`, in the cycle after the transport.
- R8: Source port 0x00 returns the program word that follows the instruction as a literal, and execution resumes at the word after that literal.
- R9: Writing destination port 0x01 makes the moved value (its low program-counter bits) the address of the next instruction.
- R10: Writing destination port 0x02 stops all further moves until reset.
- R11: A source address that no unit claims reads as zero, and a destination address that no unit claims changes no unit state.
- R12: Reset (synchronous, active high) starts execution at word 0 with both unit results at zero and `out_valid` and `in_take` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 16 | Word offered by the input unit |
| in_take | output | 1 | High in the transport cycle that reads the input unit |
| out_valid | output | 1 | One-cycle strobe for a write to the output unit |
| out_data | output | 16 | Word written to the output unit |

## Verification
Internal state shows at the ports only through later moves. A wrong operand or result register therefore appears as a wrong `out_data` value on the next strobe that reads that unit, usually within one or two moves. A fault in the sequencer shows sooner and more widely. A bad program counter, literal skip or jump moves the strobes to the wrong cycles, changes how far apart they are, or makes the input stream be read in the wrong order, within one program pass. A stop that does not hold lets a forbidden word appear a few cycles later. An unmapped address that is not ignored alters a value that is read back two moves after it.

// File: rtl/ttmove_pkg.sv
package ttmove_pkg;

    localparam int WORD_W = 16;
    localparam int PORT_W = 8;
    localparam int BLK_W  = 4;
    localparam int OFF_W  = PORT_W - BLK_W;

    // special and communication port addresses
    localparam logic [PORT_W-1:0] P_LIT  = 8'h00;
    localparam logic [PORT_W-1:0] P_PC   = 8'h01;
    localparam logic [PORT_W-1:0] P_STOP = 8'h02;
    localparam logic [PORT_W-1:0] P_IN   = 8'h10;
    localparam logic [PORT_W-1:0] P_OUT  = 8'h11;

    // functional units occupy consecutive blocks starting here
    localparam logic [BLK_W-1:0] FU_FIRST_BLOCK = 4'h2;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_LIT,
        ST_MOVE,
        ST_STOP
    } seq_state_e;

    typedef enum logic [1:0] {
        FU_ADDER,
        FU_LOGIC
    } fu_kind_e;

    typedef struct packed {
        logic [PORT_W-1:0] src;
        logic [PORT_W-1:0] dst;
    } move_word_t;

    function automatic logic [BLK_W-1:0] blk_of(input logic [PORT_W-1:0] a);
        return a[PORT_W-1:OFF_W];
    endfunction

    function automatic logic [OFF_W-1:0] off_of(input logic [PORT_W-1:0] a);
        return a[OFF_W-1:0];
    endfunction

    function automatic fu_kind_e kind_of_slot(input int slot);
        return (slot == 0) ? FU_ADDER : FU_LOGIC;
    endfunction

endpackage

// File: rtl/ttmove_seq.sv
module ttmove_seq
    import ttmove_pkg::*;
#(
    parameter int IMEM_DEPTH = 32,
    parameter logic [IMEM_DEPTH*WORD_W-1:0] PROGRAM_IMAGE = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WORD_W-1:0]     bus_data,
    output logic                  xfer_valid,
    output move_word_t            xfer_move,
    output logic [WORD_W-1:0]     lit_word,
    output logic [WORD_W-1:0]     pc_word
);
    localparam int PC_W = $clog2(IMEM_DEPTH);

    seq_state_e        st_q;
    logic [PC_W-1:0]   pc_q;
    move_word_t        ir_q;
    logic [WORD_W-1:0] lit_q;
    logic [WORD_W-1:0] cur_word;
    move_word_t        cur_move;
    logic              unused_bus_hi;

    assign cur_word      = PROGRAM_IMAGE[int'(pc_q)*WORD_W +: WORD_W];
    assign cur_move      = move_word_t'(cur_word);
    assign unused_bus_hi = ^bus_data[WORD_W-1:PC_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_FETCH;
            pc_q  <= '0;
            ir_q  <= '0;
            lit_q <= '0;
        end else begin
            case (st_q)
                ST_FETCH: begin
                    ir_q <= cur_move;
                    pc_q <= pc_q + PC_W'(1);
                    st_q <= (cur_move.src == P_LIT) ? ST_LIT : ST_MOVE;
                end
                ST_LIT: begin
                    lit_q <= cur_word;
                    pc_q  <= pc_q + PC_W'(1);
                    st_q  <= ST_MOVE;
                end
                ST_MOVE: begin
                    if (ir_q.dst == P_PC) begin
                        pc_q <= bus_data[PC_W-1:0];
                    end
                    st_q <= (ir_q.dst == P_STOP) ? ST_STOP : ST_FETCH;
                end
                default: st_q <= ST_STOP;
            endcase
        end
    end

    assign xfer_valid = (st_q == ST_MOVE);
    assign xfer_move  = ir_q;
    assign lit_word   = lit_q;
    assign pc_word    = {{(WORD_W-PC_W){1'b0}}, pc_q};

    // R2: a transport is always followed by a fetch, never another transport
    assert_single_transport_R2: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |=> !xfer_valid);

    // R10: once stopped, the sequencer and its counter stay frozen
    assert_stop_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_STOP) |=> (st_q == ST_STOP) && $stable(pc_q));

    // R8: a literal move resumes two words after its own instruction
    assert_literal_skip_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_MOVE && $past(st_q) == ST_LIT) |-> pc_q == $past(pc_q, 2) + PC_W'(2));

endmodule

// File: rtl/ttmove_fu.sv
module ttmove_fu
    import ttmove_pkg::*;
#(
    parameter fu_kind_e         KIND  = FU_ADDER,
    parameter logic [BLK_W-1:0] BLOCK = 4'h2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_valid,
    input  move_word_t        xfer_move,
    input  logic [WORD_W-1:0] bus_data,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] opnd_q;
    logic [WORD_W-1:0] result_q;
    logic [WORD_W-1:0] calc;
    logic              wr_hit;
    logic              opnd_we;
    logic              trig;
    logic              trig_code_ok;
    logic [OFF_W-1:0]  wr_off;

    assign wr_hit  = xfer_valid && (blk_of(xfer_move.dst) == BLOCK);
    assign wr_off  = off_of(xfer_move.dst);
    assign opnd_we = wr_hit && (wr_off == '0);
    assign trig    = wr_hit && trig_code_ok;

    generate
        if (KIND == FU_ADDER) begin : g_adder
            always_comb begin
                trig_code_ok = (wr_off == OFF_W'(1)) || (wr_off == OFF_W'(2));
                calc = (wr_off == OFF_W'(2)) ? (opnd_q - bus_data) : (opnd_q + bus_data);
            end
        end else begin : g_logic
            always_comb begin
                trig_code_ok = 1'b1;
                case (wr_off)
                    OFF_W'(1): calc = opnd_q & bus_data;
                    OFF_W'(2): calc = opnd_q | bus_data;
                    OFF_W'(3): calc = opnd_q ^ bus_data;
                    default: begin
                        calc = '0;
                        trig_code_ok = 1'b0;
                    end
                endcase
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_q   <= '0;
            result_q <= '0;
        end else begin
            if (opnd_we) opnd_q   <= bus_data;
            if (trig)    result_q <= calc;
        end
    end

    assign rd_data = (xfer_valid && xfer_move.src == {BLOCK, {OFF_W{1'b0}}}) ? result_q : '0;

    // R5 R11: the result changes only on a trigger write to this unit
    assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !trig |=> $stable(result_q));

    // R11: a move that does not address this unit leaves its operand alone
    assert_operand_untouched_R11: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(opnd_q));

endmodule

// File: rtl/ttmove_io.sv
module ttmove_io
    import ttmove_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_valid,
    input  move_word_t        xfer_move,
    input  logic [WORD_W-1:0] bus_data,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_take,
    output logic [WORD_W-1:0] rd_data,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);
    assign in_take = xfer_valid && (xfer_move.src == P_IN);
    assign rd_data = in_take ? in_data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= xfer_valid && (xfer_move.dst == P_OUT);
            if (xfer_valid && xfer_move.dst == P_OUT) begin
                out_data <= bus_data;
            end
        end
    end

    // R7: the output strobe never lasts two cycles
    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R6: the input is taken for one cycle per move
    assert_take_single_R6: assert property (@(posedge clk) disable iff (rst)
        in_take |=> !in_take);

endmodule

// File: rtl/ttmove_core.sv
module ttmove_core
    import ttmove_pkg::*;
#(
    parameter int IMEM_DEPTH = 32,
    parameter logic [IMEM_DEPTH*WORD_W-1:0] PROGRAM_IMAGE = '0,
    parameter int NUM_FU = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_take,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);
    logic              xfer_valid;
    move_word_t        xfer_move;
    logic [WORD_W-1:0] lit_word;
    logic [WORD_W-1:0] pc_word;
    logic [WORD_W-1:0] bus_data;
    logic [WORD_W-1:0] io_rd;
    logic [WORD_W-1:0] sys_rd;
    logic [WORD_W-1:0] fu_rd [NUM_FU];

    ttmove_seq #(
        .IMEM_DEPTH    (IMEM_DEPTH),
        .PROGRAM_IMAGE (PROGRAM_IMAGE)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .bus_data   (bus_data),
        .xfer_valid (xfer_valid),
        .xfer_move  (xfer_move),
        .lit_word   (lit_word),
        .pc_word    (pc_word)
    );

    generate
        for (genvar g = 0; g < NUM_FU; g++) begin : g_fu
            ttmove_fu #(
                .KIND  (kind_of_slot(g)),
                .BLOCK (FU_FIRST_BLOCK + BLK_W'(g))
            ) fu_i (
                .clk        (clk),
                .rst        (rst),
                .xfer_valid (xfer_valid),
                .xfer_move  (xfer_move),
                .bus_data   (bus_data),
                .rd_data    (fu_rd[g])
            );
        end
    endgenerate

    ttmove_io io_i (
        .clk        (clk),
        .rst        (rst),
        .xfer_valid (xfer_valid),
        .xfer_move  (xfer_move),
        .bus_data   (bus_data),
        .in_data    (in_data),
        .in_take    (in_take),
        .rd_data    (io_rd),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    always_comb begin
        sys_rd = '0;
        if (xfer_valid && xfer_move.src == P_LIT) sys_rd = lit_word;
        if (xfer_valid && xfer_move.src == P_PC)  sys_rd = pc_word;
    end

    // each source drives zero unless addressed, so the bus is an OR of all
    always_comb begin
        bus_data = sys_rd | io_rd;
        for (int k = 0; k < NUM_FU; k++) begin
            bus_data = bus_data | fu_rd[k];
        end
    end

    // R11: with no move in flight the bus carries nothing
    assert_bus_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !xfer_valid |-> bus_data == '0);

endmodule

// File: tb/ttmove_core_tb.sv
module ttmove_core_tb_top;
    localparam int DEPTH = 32;
    localparam int NV    = 8;

    localparam logic [15:0] VX [NV] = '{16'h0001, 16'hFFFF, 16'h8000, 16'h1234,
                                        16'h0000, 16'hAAAA, 16'h00FF, 16'h7FFF};
    localparam logic [15:0] VY [NV] = '{16'h0002, 16'h0001, 16'h8000, 16'h5678,
                                        16'h0000, 16'h5555, 16'hFF00, 16'h0003};

    // R1: word = {source port, destination port}
    function automatic logic [DEPTH*16-1:0] main_image();
        logic [15:0] w [DEPTH];
        logic [DEPTH*16-1:0] img;
        for (int i = 0; i < DEPTH; i++) w[i] = 16'h0000;
        w[0]  = 16'h1020; // in -> adder operand
        w[1]  = 16'h1030; // in -> logic operand
        w[2]  = 16'h1021; // in -> adder add trigger
        w[3]  = 16'h2011; // adder -> out
        w[4]  = 16'h1033; // in -> logic xor trigger
        w[5]  = 16'h3011; // logic -> out
        w[6]  = 16'h2020; // adder -> adder operand
        w[7]  = 16'h3022; // logic -> adder sub trigger
        w[8]  = 16'h2011; // adder -> out
        w[9]  = 16'h0001; // literal -> jump
        w[10] = 16'h0000;
        for (int i = 0; i < DEPTH; i++) img[i*16 +: 16] = w[i];
        return img;
    endfunction

    function automatic logic [DEPTH*16-1:0] edge_image();
        logic [15:0] w [DEPTH];
        logic [DEPTH*16-1:0] img;
        for (int i = 0; i < DEPTH; i++) w[i] = 16'h0000;
        w[0]  = 16'h0030; w[1]  = 16'h0F0F;
        w[2]  = 16'h0031; w[3]  = 16'h00FF;
        w[4]  = 16'h3011;
        w[5]  = 16'h0032; w[6]  = 16'hF000;
        w[7]  = 16'h3011;
        w[8]  = 16'hEE11;
        w[9]  = 16'h00EE; w[10] = 16'h1234;
        w[11] = 16'h3011;
        w[12] = 16'h2011;
        w[13] = 16'h0002; w[14] = 16'h0000;
        w[15] = 16'h0011; w[16] = 16'hBAD1;
        for (int i = 0; i < DEPTH; i++) img[i*16 +: 16] = w[i];
        return img;
    endfunction

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] in_data = 16'h0;
    logic        in_take, out_valid;
    logic [15:0] out_data;
    logic        in_take2, out_valid2;
    logic [15:0] out_data2;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int sidx = 0;
    bit take_pend = 0;
    int d2_n = 0;
    logic [15:0] d2_data [8];
    int d2_cyc [8];
    bit finished = 0;

    always #4 clk = ~clk;

    ttmove_core #(.IMEM_DEPTH(DEPTH), .PROGRAM_IMAGE(main_image())) dut_i (
        .clk(clk), .rst(rst), .in_data(in_data), .in_take(in_take),
        .out_valid(out_valid), .out_data(out_data));

    ttmove_core #(.IMEM_DEPTH(DEPTH), .PROGRAM_IMAGE(edge_image())) dut2_i (
        .clk(clk), .rst(rst), .in_data(in_data), .in_take(in_take2),
        .out_valid(out_valid2), .out_data(out_data2));

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] stream_word(input int k);
        if (k >= 4*NV) return 16'h0;
        return ((k % 4) < 2) ? VX[k/4] : VY[k/4];
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // R6: feed the next word once the previous one has been taken
    always @(negedge clk) begin
        if (!rst) begin
            if (take_pend) sidx++;
            take_pend = in_take;
        end
        in_data = stream_word(sidx);
    end

    always @(negedge clk) begin
        if (!rst && out_valid2 && d2_n < 8) begin
            d2_data[d2_n] = out_data2;
            d2_cyc[d2_n]  = cyc;
            d2_n++;
        end
    end

    always @(negedge clk) begin
        if (cyc > 20000 && !finished) begin
            finished = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog R2: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic wait_strobe();
        do @(negedge clk); while (!out_valid && cyc < 20000);
    endtask

    initial begin
        logic [15:0] s, x;
        // R12: reset state
        repeat (3) @(negedge clk);
        check("R12 out_valid in reset", {15'h0, out_valid}, 16'h0);
        check("R12 in_take in reset",   {15'h0, in_take},   16'h0);
        check("R12 out_data in reset",  out_data2,          16'h0);
        @(negedge clk);
        rst = 1'b0;

        // vector table, one pass of the program per entry (R9 jump loops it)
        for (int i = 0; i < NV; i++) begin
            s = VX[i] + VY[i];
            x = VX[i] ^ VY[i];
            wait_strobe();
            check($sformatf("R3 sum vec %0d", i), out_data, s);
            wait_strobe();
            check($sformatf("R4 xor vec %0d", i), out_data, x);
            wait_strobe();
            check($sformatf("R5 chained sub vec %0d", i), out_data, s - x);
        end
        check("R6 R9 input words consumed", 16'(sidx), 16'(4*NV));

        // directed corner cases on the second program
        repeat (50) @(negedge clk);
        check("R7 R10 strobe count after stop", 16'(d2_n), 16'd5);
        check("R8 literal and", d2_data[0], 16'h000F);
        check("R4 or reuses held operand", d2_data[1], 16'hFF0F);
        check("R11 unmapped source reads zero", d2_data[2], 16'h0000);
        check("R11 unmapped destination no effect", d2_data[3], 16'hFF0F);
        check("R12 adder result zero after reset", d2_data[4], 16'h0000);
        check("R2 R8 gap literal+move", 16'(d2_cyc[1] - d2_cyc[0]), 16'd5);
        check("R2 gap plain move", 16'(d2_cyc[2] - d2_cyc[1]), 16'd2);
        check("R8 gap after ignored literal", 16'(d2_cyc[3] - d2_cyc[2]), 16'd5);
        check("R2 gap plain move 2", 16'(d2_cyc[4] - d2_cyc[3]), 16'd2);
        check("R10 no strobe after stop", {15'h0, out_valid2}, 16'h0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule